// File: doc/BRIEF.md
# Vehicle Bus Frame CRC-8 Unit

This block computes the 8-bit frame check byte used on a single-wire vehicle network. It holds a remainder register that a start strobe sets to all ones. Each byte presented with a valid strobe is folded into the remainder in one clock cycle. The eight serial shift steps, most significant bit first, are unrolled in combinational logic. The divisor polynomial is x^8 + x^4 + x^3 + x^2 + 1.

To transmit, the host enables generate mode and feeds every byte of the frame that follows the start-of-frame symbol. The bitwise inverse of the remainder then appears on the CRC output, ready to be sent after the data. To receive, the host enables check mode and feeds the data bytes plus the received check byte. When the host raises the end-of-frame strobe, the unit registers a verdict. An intact frame always leaves the fixed residue 0xC4, so any other remainder counts as a failure. The verdict holds until the next start strobe.

Top module: `vbus_crc8`

## Requirements
- R1: While reset is held and after it is released, the remainder is 0xFF, so crc_o reads 0x00, and verdict_vld_o and crc_ok_o are both 0.
- R2: Each cycle with byte_vld_i high folds byte_i into the remainder, most significant bit first. Each bit step shifts the remainder left and XORs in 0x1D when the leaving bit differs from the data bit. The new value is visible on crc_o in the next cycle.
- R3: crc_o is the bitwise inverse of the remainder. After a start, the ASCII bytes "123456789" give crc_o = 0x4B.
- R4: start_i sets the remainder to 0xFF, so crc_o reads 0x00 in the next cycle. If byte_vld_i is high in the same cycle, that byte is folded into 0xFF as the first byte of the new frame.
- R5: When byte_vld_i and start_i are both low, the remainder and crc_o keep their values whatever byte_i carries.
- R6: In check mode (mode_chk_i = 1), frame_end_i sets verdict_vld_o to 1 in the next cycle. crc_ok_o is then 1 exactly when the remainder equals 0xC4, that is when crc_o was 0x3B. An empty frame therefore fails.
- R7: In generate mode (mode_chk_i = 0), frame_end_i sets verdict_vld_o to 1 and crc_ok_o to 1 in the next cycle.
- R8: A byte presented in the same cycle as frame_end_i is included in the remainder that the verdict judges.
- R9: Once verdict_vld_o is 1, further frame_end_i strobes and bytes leave verdict_vld_o and crc_ok_o unchanged until start_i.
- R10: start_i clears verdict_vld_o and crc_ok_o to 0 in the next cycle. It takes priority over a frame_end_i strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start of a new frame: presets the remainder, clears the verdict |
| byte_vld_i | input | 1 | byte_i carries a frame byte this cycle |
| byte_i | input | DATA_W (8) | Frame byte, most significant bit sent first |
| mode_chk_i | input | 1 | 1 = check received frame, 0 = generate check byte |
| frame_end_i | input | 1 | End of frame: evaluate the verdict |
| crc_o | output | 8 | Inverted remainder, the check byte to transmit |
| verdict_vld_o | output | 1 | Verdict registered and held |
| crc_ok_o | output | 1 | Verdict: 1 = pass, 0 = CRC failure |

## Verification
Several properties are checked on every cycle. A start preset shows up as 0x00 on crc_o. Idle cycles leave crc_o stable. A start clears the verdict, and a verdict holds until the next start. Generate mode always passes, and in check mode the verdict agrees with the 0xC4 residue. What only the bench scenarios can show is the arithmetic itself: the known 0x4B result, the residue reached after an appended check byte, and a failure after a single corrupted byte. The bench also covers random round trips and the same-cycle cases of start with a byte and end with a byte.

// File: rtl/vbus_crc_pkg.sv
package vbus_crc_pkg;

  localparam int unsigned CRC_W = 8;

  typedef logic [CRC_W-1:0] crc_t;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } crc_mode_e;

endpackage

// File: rtl/vbus_rst_sync.sv
module vbus_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/vbus_crc8_fold.sv
module vbus_crc8_fold
  import vbus_crc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter crc_t        POLY   = 8'h1D
) (
  input  crc_t              rem_i,
  input  logic [DATA_W-1:0] data_i,
  output crc_t              rem_o
);

  // stage[k] is the remainder after k bit steps
  crc_t stage [0:DATA_W];

  assign stage[0] = rem_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic fb;
    assign fb           = stage[b][CRC_W-1] ^ data_i[DATA_W-1-b];
    assign stage[b+1]   = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign rem_o = stage[DATA_W];

endmodule

// File: rtl/vbus_crc8_state.sv
module vbus_crc8_state
  import vbus_crc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter crc_t        POLY   = 8'h1D,
  parameter crc_t        PRESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output crc_t              rem_q_o,
  output crc_t              rem_upd_o
);

  crc_t rem_q;
  crc_t rem_base;
  crc_t rem_fold;
  crc_t rem_d;
  logic rem_en;

  vbus_crc8_fold #(
    .DATA_W (DATA_W),
    .POLY   (POLY)
  ) i_fold (
    .rem_i  (rem_base),
    .data_i (byte_i),
    .rem_o  (rem_fold)
  );

  always_comb begin
    rem_base = start_i ? PRESET : rem_q;
    rem_en   = start_i | byte_vld_i;
    if (byte_vld_i) begin
      rem_d = rem_fold;
    end else begin
      rem_d = rem_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= PRESET;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign rem_q_o   = rem_q;
  assign rem_upd_o = rem_d;

endmodule

// File: rtl/vbus_crc8_verdict.sv
module vbus_crc8_verdict
  import vbus_crc_pkg::*;
#(
  parameter crc_t RESIDUE = 8'hC4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      frame_end_i,
  input  crc_mode_e mode_i,
  input  crc_t      rem_upd_i,
  output logic      vld_o,
  output logic      ok_o
);

  logic vld_q, vld_d;
  logic ok_q, ok_d;
  logic vd_en;

  always_comb begin
    vld_d = vld_q;
    ok_d  = ok_q;
    vd_en = 1'b0;
    if (start_i) begin
      vd_en = 1'b1;
      vld_d = 1'b0;
      ok_d  = 1'b0;
    end else if (frame_end_i && !vld_q) begin
      vd_en = 1'b1;
      vld_d = 1'b1;
      if (mode_i == MODE_GEN) begin
        ok_d = 1'b1;
      end else begin
        ok_d = (rem_upd_i == RESIDUE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
    end else if (vd_en) begin
      vld_q <= vld_d;
      ok_q  <= ok_d;
    end
  end

  assign vld_o = vld_q;
  assign ok_o  = ok_q;

endmodule

// File: rtl/vbus_crc8.sv
module vbus_crc8
  import vbus_crc_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter crc_t        POLY        = 8'h1D,
  parameter crc_t        PRESET      = 8'hFF,
  parameter crc_t        RESIDUE     = 8'hC4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              mode_chk_i,
  input  logic              frame_end_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              verdict_vld_o,
  output logic              crc_ok_o
);

  logic      rst_n_sync;
  crc_t      rem_q;
  crc_t      rem_upd;
  crc_mode_e mode;

  assign mode = crc_mode_e'(mode_chk_i);

  vbus_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  vbus_crc8_state #(
    .DATA_W (DATA_W),
    .POLY   (POLY),
    .PRESET (PRESET)
  ) i_state (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .rem_q_o    (rem_q),
    .rem_upd_o  (rem_upd)
  );

  vbus_crc8_verdict #(
    .RESIDUE (RESIDUE)
  ) i_verdict (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .start_i     (start_i),
    .frame_end_i (frame_end_i),
    .mode_i      (mode),
    .rem_upd_i   (rem_upd),
    .vld_o       (verdict_vld_o),
    .ok_o        (crc_ok_o)
  );

  assign crc_o = ~rem_q;

endmodule

// File: rtl/vbus_crc8_chk.sv
module vbus_crc8_chk
  import vbus_crc_pkg::*;
#(
  parameter crc_t PRESET  = 8'hFF,
  parameter crc_t RESIDUE = 8'hC4
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic byte_vld_i,
  input logic frame_end_i,
  input logic mode_chk_i,
  input crc_t crc_o,
  input logic verdict_vld_o,
  input logic crc_ok_o
);

  AST_START_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !byte_vld_i) |=> (crc_o == ~PRESET)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !byte_vld_i) |=> $stable(crc_o)); // R5

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!verdict_vld_o && !crc_ok_o)); // R10

  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld_o && !start_i) |=> (verdict_vld_o && $stable(crc_ok_o))); // R9

  AST_OK_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok_o |-> verdict_vld_o); // R6

  AST_GEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && !start_i && !verdict_vld_o && !mode_chk_i) |=> (verdict_vld_o && crc_ok_o)); // R7

  AST_CHK_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && !start_i && !verdict_vld_o && mode_chk_i && !byte_vld_i)
      |=> (verdict_vld_o && (crc_ok_o == (~$past(crc_o) == RESIDUE)))); // R6

endmodule

bind vbus_crc8 vbus_crc8_chk #(
  .PRESET  (PRESET),
  .RESIDUE (RESIDUE)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .start_i       (start_i),
  .byte_vld_i    (byte_vld_i),
  .frame_end_i   (frame_end_i),
  .mode_chk_i    (mode_chk_i),
  .crc_o         (crc_o),
  .verdict_vld_o (verdict_vld_o),
  .crc_ok_o      (crc_ok_o)
);

// File: tb/test_vbus_crc8.sv
`timescale 1ns/100ps
module test_vbus_crc8;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       byte_vld_i;
  logic [7:0] byte_i;
  logic       mode_chk_i;
  logic       frame_end_i;
  logic [7:0] crc_o;
  logic       verdict_vld_o;
  logic       crc_ok_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    string      req;
    bit         is_verdict;
    logic [7:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];

  vbus_crc8 i_vbus_crc8 (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .byte_vld_i    (byte_vld_i),
    .byte_i        (byte_i),
    .mode_chk_i    (mode_chk_i),
    .frame_end_i   (frame_end_i),
    .crc_o         (crc_o),
    .verdict_vld_o (verdict_vld_o),
    .crc_ok_o      (crc_ok_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference: bit-serial divide, MSB first, polynomial 0x1D
  function automatic logic [7:0] ref_fold(input logic [7:0] r, input logic [7:0] d);
    logic [7:0] x;
    x = r;
    for (int i = 0; i < 8; i++) begin
      if (x[7] ^ d[7-i]) x = {x[6:0], 1'b0} ^ 8'h1D;
      else               x = {x[6:0], 1'b0};
    end
    return x;
  endfunction

  function automatic logic [7:0] ref_crc(input logic [7:0] b[$]);
    logic [7:0] r;
    r = 8'hFF;
    foreach (b[i]) r = ref_fold(r, b[i]);
    return ~r;
  endfunction

  // monitor: compare queued expectations against outputs at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      act = it.is_verdict ? {6'd0, verdict_vld_o, crc_ok_o} : crc_o;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: got %02h expected %02h", it.req, act, it.exp);
      end
    end
  end

  task automatic cyc(input bit st, input bit vl, input logic [7:0] d, input bit en);
    @(posedge clk);
    #1;
    start_i     = st;
    byte_vld_i  = vl;
    byte_i      = d;
    frame_end_i = en;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 8'($urandom), 1'b0);
  endtask

  task automatic exp_crc(input string r, input logic [7:0] e);
    sb_item_t it;
    it.req = r; it.is_verdict = 1'b0; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic exp_verdict(input string r, input bit v, input bit ok);
    sb_item_t it;
    it.req = r; it.is_verdict = 1'b1; it.exp = {6'd0, v, ok};
    sb_q.push_back(it);
  endtask

  task automatic send(input logic [7:0] b[$]);
    foreach (b[i]) cyc(1'b0, 1'b1, b[i], 1'b0);
  endtask

  task automatic settle();
    idle();
    @(negedge clk);
    #1;
  endtask

  logic [7:0] ascii9[$];
  logic [7:0] pkt[$];
  logic [7:0] c;

  initial begin
    rst_n = 1'b0; start_i = 0; byte_vld_i = 0; byte_i = 0; mode_chk_i = 0; frame_end_i = 0;
    ascii9 = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    repeat (3) @(posedge clk);
    exp_crc("R1 reset crc", 8'h00);
    exp_verdict("R1 reset verdict", 1'b0, 1'b0);
    #1 rst_n = 1'b1;
    repeat (4) idle();
    exp_crc("R1 after release", 8'h00);
    exp_verdict("R1 verdict after release", 1'b0, 1'b0);
    settle();

    // R2 R3: known vector in generate mode
    mode_chk_i = 1'b0;
    cyc(1, 0, 8'h00, 0);
    idle();
    exp_crc("R4 preset", 8'h00);
    send(ascii9);
    idle();
    exp_crc("R3 known vector", 8'h4B);
    settle();

    // R5: idle with changing data leaves crc
    repeat (5) idle();
    exp_crc("R5 idle garbage", 8'h4B);
    settle();

    // R7: generate mode verdict always passes
    cyc(0, 0, 8'h00, 1);
    idle();
    exp_verdict("R7 gen pass", 1'b1, 1'b1);
    settle();

    // R10: start clears verdict
    cyc(1, 0, 8'h00, 0);
    idle();
    exp_verdict("R10 start clears", 1'b0, 1'b0);
    exp_crc("R4 restart preset", 8'h00);
    settle();

    // R6: check mode with correct trailing byte
    mode_chk_i = 1'b1;
    send(ascii9);
    cyc(0, 1, 8'h4B, 0);
    idle();
    exp_crc("R6 residue seen", 8'h3B);
    cyc(0, 0, 8'h00, 1);
    idle();
    exp_verdict("R6 good frame", 1'b1, 1'b1);
    settle();

    // R9: later bytes and ends do not disturb verdict
    cyc(0, 1, 8'h77, 0);
    cyc(0, 1, 8'h01, 1);
    idle();
    exp_verdict("R9 verdict held", 1'b1, 1'b1);
    settle();

    // R6: corrupted byte fails
    pkt = ascii9;
    pkt[4] = 8'h75;
    cyc(1, 0, 8'h00, 0);
    send(pkt);
    cyc(0, 1, 8'h4B, 0);
    cyc(0, 0, 8'h00, 1);
    idle();
    exp_verdict("R6 corrupt frame", 1'b1, 1'b0);
    settle();

    // R4: start together with the first byte
    mode_chk_i = 1'b0;
    cyc(1, 1, ascii9[0], 0);
    for (int i = 1; i < 9; i++) cyc(0, 1, ascii9[i], 0);
    idle();
    exp_crc("R4 start with byte", 8'h4B);
    settle();

    // R8: end strobe together with the check byte
    mode_chk_i = 1'b1;
    cyc(1, 0, 8'h00, 0);
    send(ascii9);
    cyc(0, 1, 8'h4B, 1);
    idle();
    exp_verdict("R8 end with byte", 1'b1, 1'b1);
    settle();

    // R10: start and end together, start wins
    cyc(1, 0, 8'h00, 1);
    idle();
    exp_verdict("R10 start beats end", 1'b0, 1'b0);
    exp_crc("R10 preset", 8'h00);
    settle();

    // R6: empty frame fails (remainder 0xFF)
    cyc(0, 0, 8'h00, 1);
    idle();
    exp_verdict("R6 empty frame", 1'b1, 1'b0);
    settle();

    // R2: random round trips
    for (int k = 0; k < 20; k++) begin
      int len;
      len = 1 + ($urandom % 12);
      pkt.delete();
      for (int j = 0; j < len; j++) pkt.push_back(8'($urandom));
      c = ref_crc(pkt);
      mode_chk_i = 1'b0;
      cyc(1, 0, 8'h00, 0);
      send(pkt);
      idle();
      exp_crc("R2 random generate", c);
      settle();
      mode_chk_i = 1'b1;
      cyc(1, 0, 8'h00, 0);
      send(pkt);
      cyc(0, 1, c, 0);
      cyc(0, 0, 8'h00, 1);
      idle();
      exp_verdict("R6 random check", 1'b1, 1'b1);
      settle();
    end

    settle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule